// File: doc/BRIEF.md
# Shared-Direction Card Data Buffer

This block is the word buffer between the host bus and the serial engine of a memory-card host controller. One storage array of 16 words, 32 bits each, carries data in whichever direction the controller is moving it. Two mode inputs select the direction. In transmit, the host pushes words and the card engine pulls them. In receive, the card engine pushes and the host pulls. With neither mode asserted, or both, the buffer sits idle and is kept flushed.

Two counters are loaded together by a one-cycle data-control enable pulse from a programmed byte length. The host-view counter holds the number of words still to pass the host port. The byte length is rounded up to whole words when it is loaded. The card-view counter holds the bytes still to pass the card engine, and it steps down on a per-byte strobe from that engine. While a transfer is running the two counters drift apart. When a receive transfer ends, the host-view counter equals the number of words left to drain. A host may drain the buffer either by that count or by polling the empty flag.

Top module: `dir_data_fifo`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `level`=0, both counters are 0, and `mode_err`, `overrun` and `underrun` are 0.
- R2: Words come out in the order they went in. In transmit, host writes appear on `card_rdata`. In receive, card writes appear on `host_rdata`. The read data port shows the oldest word, without waiting for a clock edge.
- R3: `level` (5 bits) counts the stored words from 0 to 16. `full` is 1 exactly at 16 and `empty` is 1 exactly at 0.
- R4: A `load_en` pulse sets `words_left` to (`xfer_len`+3)>>2 and `bytes_left` to `xfer_len`, and clears `overrun` and `underrun`. In the same cycle, a load takes priority over any decrement.
- R5: `words_left` drops by one for each host word that is accepted: a write in transmit, or a read in receive. It stops at 0. After a receive of a whole buffer, `words_left` equals `level` while the host drains.
- R6: `bytes_left` drops by one on each `card_byte` strobe, in any mode, independently of `words_left`. It stops at 0.
- R7: When neither mode is active, the occupancy is cleared from the next cycle on, and writes on both sides are ignored.
- R8: When `tx_mode` and `rx_mode` are both 1, `mode_err` is 1 and the buffer behaves as in R7.
- R9: A push while full is discarded and sets the sticky `overrun` flag. A pop while empty is discarded and sets the sticky `underrun` flag.
- R10: The port facing the wrong way is ignored. In transmit, `card_wr` and `host_rd` change neither `level` nor `words_left`. In receive, `host_wr` and `card_rd` change neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_mode | input | 1 | Transmit direction select |
| rx_mode | input | 1 | Receive direction select |
| load_en | input | 1 | Data-control enable pulse, loads both counters |
| xfer_len | input | 16 | Programmed transfer length in bytes |
| host_wr | input | 1 | Host word write (transmit) |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host word read (receive) |
| host_rdata | output | 32 | Oldest stored word, host view |
| empty | output | 1 | Buffer holds no word |
| full | output | 1 | Buffer holds 16 words |
| level | output | 5 | Stored word count |
| words_left | output | 15 | Host-side words still to move |
| card_rd | input | 1 | Engine word pull (transmit) |
| card_rdata | output | 32 | Oldest stored word, engine view |
| card_wr | input | 1 | Engine word push (receive) |
| card_wdata | input | 32 | Engine write data |
| card_byte | input | 1 | One byte moved on the card line |
| bytes_left | output | 16 | Card-side bytes still to move |
| mode_err | output | 1 | Both direction selects asserted |
| overrun | output | 1 | Sticky: push attempted while full |
| underrun | output | 1 | Sticky: pop attempted while empty |

## Verification
Some properties are checked on every cycle. The occupancy never exceeds the depth. An idle or conflicting mode leaves the buffer empty one cycle later. A counter at zero stays at zero unless it is reloaded. The sticky flags stay set until a load clears them. Other behaviour needs the bench's scenarios. Ordering of data, the rounding of the word count, the equality of `words_left` and `level` while draining after a receive, and the rejection of wrong-direction strobes all depend on chosen sequences of data and strobes. The bench sweeps every fill depth from 0 to 16 in both directions to cover them.

// File: rtl/dir_data_fifo.sv
module dir_data_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode,
  input  logic              rx_mode,
  input  logic              load_en,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH):0] level,
  output logic [LEN_W-2:0]  words_left,
  input  logic              card_rd,
  output logic [DATA_W-1:0] card_rdata,
  input  logic              card_wr,
  input  logic [DATA_W-1:0] card_wdata,
  input  logic              card_byte,
  output logic [LEN_W-1:0]  bytes_left,
  output logic              mode_err,
  output logic              overrun,
  output logic              underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int WW = LEN_W - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic [LEN_W:0] len_pad;
  logic tx_on, rx_on, active, push_req, pop_req, push_ok, pop_ok, host_word;

  assign tx_on  = tx_mode & ~rx_mode;
  assign rx_on  = rx_mode & ~tx_mode;
  assign active = tx_on | rx_on;
  assign mode_err = tx_mode & rx_mode;

  assign empty = (cnt == 0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign level = cnt;

  assign push_req  = (tx_on & host_wr) | (rx_on & card_wr);
  assign pop_req   = (tx_on & card_rd) | (rx_on & host_rd);
  assign push_ok   = push_req & ~full;
  assign pop_ok    = pop_req & ~empty;
  assign host_word = (tx_on & host_wr & ~full) | (rx_on & host_rd & ~empty);

  assign host_rdata = mem[rd_ptr];
  assign card_rdata = mem[rd_ptr];
  assign len_pad    = {1'b0, xfer_len} + (LEN_W+1)'(3);

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr] <= tx_on ? host_wdata : card_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (!active) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_left <= '0;
      bytes_left <= '0;
      overrun    <= 1'b0;
      underrun   <= 1'b0;
    end else if (load_en) begin
      words_left <= len_pad[LEN_W:2];
      bytes_left <= xfer_len;
      overrun    <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      if (host_word && words_left != '0) words_left <= words_left - 1'b1;
      if (card_byte && bytes_left != '0) bytes_left <= bytes_left - 1'b1;
      if (push_req && full)  overrun  <= 1'b1;
      if (pop_req && empty)  underrun <= 1'b1;
    end
  end

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH)); // R3
  AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_mode ^ rx_mode) |=> empty); // R7
  AST_CONFLICT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && rx_mode) |=> (level == 0)); // R8
  AST_WORDS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (words_left == '0 && !load_en) |=> (words_left == '0)); // R5
  AST_BYTES_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (bytes_left == '0 && !load_en) |=> (bytes_left == '0)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !load_en) |=> overrun); // R9
  AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !load_en) |=> underrun); // R9
endmodule

// File: tb/dir_data_fifo_bench.sv
module dir_data_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic tx_mode = 0, rx_mode = 0, load_en = 0, host_wr = 0, host_rd = 0;
  logic card_rd = 0, card_wr = 0, card_byte = 0;
  logic [15:0] xfer_len = 0;
  logic [31:0] host_wdata = 0, card_wdata = 0, host_rdata, card_rdata;
  logic empty, full, mode_err, overrun, underrun;
  logic [4:0] level;
  logic [14:0] words_left;
  logic [15:0] bytes_left;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  dir_data_fifo u_dir_data_fifo (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .rx_mode(rx_mode),
    .load_en(load_en), .xfer_len(xfer_len), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .empty(empty), .full(full), .level(level), .words_left(words_left),
    .card_rd(card_rd), .card_rdata(card_rdata), .card_wr(card_wr),
    .card_wdata(card_wdata), .card_byte(card_byte), .bytes_left(bytes_left),
    .mode_err(mode_err), .overrun(overrun), .underrun(underrun));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int k, int i);
    return 32'hC3A50000 ^ (k * 32'h01000100) ^ (i * 32'h00010001);
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic do_load(input logic [15:0] len);
    xfer_len = len; load_en = 1; tick(); load_en = 0; tick();
  endtask

  task automatic set_mode(input logic t, input logic r);
    tx_mode = t; rx_mode = r; tick();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); rst_n = 1; tick();
    // R1
    chk("R1 empty", empty, 1); chk("R1 full", full, 0); chk("R1 level", level, 0);
    chk("R1 words", words_left, 0); chk("R1 bytes", bytes_left, 0);
    chk("R1 flags", {mode_err, overrun, underrun}, 0);

    // R4 rounding sweep
    for (int len = 0; len < 41; len++) begin
      do_load(16'(len));
      chk("R4 words", words_left, (len + 3) >> 2);
      chk("R4 bytes", bytes_left, len);
    end
    do_load(16'hFFFF);
    chk("R4 words max", words_left, 16384);

    // R2/R3/R5 transmit sweep
    for (int k = 0; k <= 16; k++) begin
      set_mode(0, 0);
      set_mode(1, 0);
      do_load(16'(4 * 16));
      for (int i = 0; i < k; i++) begin
        host_wr = 1; host_wdata = pat(k, i); tick();
      end
      host_wr = 0; tick();
      chk("R3 tx level", level, k);
      chk("R3 tx full", full, k == 16);
      chk("R3 tx empty", empty, k == 0);
      chk("R5 tx words", words_left, 16 - k);
      for (int i = 0; i < k; i++) begin
        chk("R2 tx order", card_rdata, pat(k, i));
        card_rd = 1; tick();
      end
      card_rd = 0; tick();
      chk("R2 tx drained", empty, 1);
      chk("R5 tx words unchanged by card", words_left, 16 - k);
    end

    // R2/R5 receive sweep: fill whole buffer, host drains k words
    for (int k = 0; k <= 16; k++) begin
      set_mode(0, 0);
      set_mode(0, 1);
      do_load(16'(4 * 16));
      for (int i = 0; i < 16; i++) begin
        card_wr = 1; card_wdata = pat(k + 40, i); tick();
      end
      card_wr = 0; tick();
      chk("R3 rx full", full, 1);
      chk("R5 rx words before", words_left, 16);
      for (int i = 0; i < k; i++) begin
        chk("R2 rx order", host_rdata, pat(k + 40, i));
        host_rd = 1; tick();
      end
      host_rd = 0; tick();
      chk("R5 rx words", words_left, 16 - k);
      chk("R5 words equals level", words_left, 15'(level));
    end

    // R9 overrun
    set_mode(0, 0); set_mode(1, 0); do_load(16'd100);
    for (int i = 0; i < 17; i++) begin
      host_wr = 1; host_wdata = pat(99, i); tick();
    end
    host_wr = 0; tick();
    chk("R9 overrun level", level, 16);
    chk("R9 overrun flag", overrun, 1);
    chk("R9 overrun words", words_left, 25 - 16);
    chk("R9 overrun head", card_rdata, pat(99, 0));
    do_load(16'd4);
    chk("R4 load clears overrun", overrun, 0);
    // R10 wrong direction in transmit
    card_wr = 1; host_rd = 1; card_wdata = 32'h1; tick();
    card_wr = 0; host_rd = 0; tick();
    chk("R10 tx level", level, 16);
    chk("R10 tx words", words_left, 1);
    // R5 saturation: words 1, write more after draining
    for (int i = 0; i < 16; i++) begin card_rd = 1; tick(); end
    card_rd = 0;
    for (int i = 0; i < 3; i++) begin host_wr = 1; host_wdata = pat(7, i); tick(); end
    host_wr = 0; tick();
    chk("R5 saturate words", words_left, 0);
    chk("R5 saturate level", level, 3);

    // R9 underrun
    set_mode(0, 0); set_mode(0, 1);
    host_rd = 1; tick(); host_rd = 0; tick();
    chk("R9 underrun flag", underrun, 1);
    chk("R9 underrun level", level, 0);
    // R10 wrong direction in receive
    do_load(16'd8);
    host_wr = 1; card_rd = 1; tick(); host_wr = 0; card_rd = 0; tick();
    chk("R10 rx level", level, 0);
    chk("R10 rx words", words_left, 2);
    chk("R4 load clears underrun", underrun, 0);

    // R7 idle ignores writes and flushes
    card_wr = 1; card_wdata = 32'h5; tick(); tick(); card_wr = 0; tick();
    chk("R7 pre level", level, 2);
    set_mode(0, 0);
    chk("R7 flushed", empty, 1);
    host_wr = 1; card_wr = 1; tick(); host_wr = 0; card_wr = 0; tick();
    chk("R7 idle ignore", level, 0);

    // R8 conflict
    set_mode(1, 0);
    host_wr = 1; tick(); tick(); host_wr = 0; tick();
    chk("R8 pre level", level, 2);
    tx_mode = 1; rx_mode = 1;
    #1 chk("R8 mode_err", mode_err, 1);
    tick();
    chk("R8 flushed", level, 0);
    host_wr = 1; card_wr = 1; tick(); host_wr = 0; card_wr = 0; tick();
    chk("R8 ignore", level, 0);
    set_mode(0, 0);
    chk("R8 err clear", mode_err, 0);

    // R6 byte counter
    do_load(16'd10);
    for (int i = 0; i < 3; i++) begin card_byte = 1; tick(); end
    card_byte = 0; tick();
    chk("R6 bytes 7", bytes_left, 7);
    chk("R6 words independent", words_left, 3);
    for (int i = 0; i < 9; i++) begin card_byte = 1; tick(); end
    card_byte = 0; tick();
    chk("R6 bytes floor", bytes_left, 0);
    card_byte = 1; do_load(16'd5);
    card_byte = 0;
    chk("R4 load priority", bytes_left, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule